// File: doc/BRIEF.md
# USB Endpoint IN Handshake Controller

This block is the packet-level transmit side of a single USB device endpoint with one packet buffer. Firmware fills a byte FIFO through a data register, one byte per write. An empty packet is allowed. Firmware then arms the endpoint by setting a packet-ready flag. When the packet engine presents an IN token, the block answers DATA and streams the stored bytes, or answers NAK if nothing is armed. It then waits for the host's ACK. On ACK it releases the FIFO, drops packet-ready and raises a completion flag. That flag holds the endpoint interrupt high until firmware clears it. If no ACK arrives before a timeout, the packet stays armed and is resent in full on the next IN token.

The ready flag and the completion flag are independent state bits. Firmware may load and arm the next packet while the previous completion is still pending, and clear the completion afterwards. The block also tracks SETUP tokens with a setup-seen flag that raises the interrupt. While that flag is set, every OUT token is answered with NAK. Status flags are cleared by writing ones to a clear register. A hardware set in the same cycle as a clear wins.

The outgoing byte stream is valid/ready. The block holds `tx_valid`, `tx_data` and `tx_last` steady until `tx_ready` is seen high. A byte moves on each clock edge where both are high. The token input is also valid/ready: `tok_ready` is high only while the engine is idle, and a token is taken on an edge where `tok_valid` and `tok_ready` are both high. All register and status pins are plain levels or single-cycle strobes.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After reset, pkt_ready, tx_done, setup_seen, wr_err, irq, resp_valid and tx_valid are all 0, fifo_level is 0 and tok_ready is 1.
- R2: A write to address 0 (data port) while pkt_ready is 0 and fifo_level is below DEPTH appends wr_data[7:0] to the FIFO and raises fifo_level by one.
- R3: A data-port write while pkt_ready is 1, or while the FIFO already holds DEPTH bytes, leaves fifo_level and the stored bytes unchanged and sets wr_err, which stays set until cleared.
- R4: A write to address 1 with bit 0 set raises pkt_ready. An IN token (tok_kind 0) accepted while pkt_ready is 1 produces, one cycle later, a one-cycle resp_valid with resp_kind 0 (DATA). The stored bytes then stream out in write order, with tx_last on the final byte. An empty packet answers DATA and sends no bytes.
- R5: An IN token accepted while pkt_ready is 0 is answered with resp_kind 1 (NAK) and no byte is sent, even if the FIFO holds bytes.
- R6: hs_ack high while the block waits for the handshake sets tx_done, clears pkt_ready and empties the FIFO. irq is 1 whenever tx_done or setup_seen is 1.
- R7: If no hs_ack arrives within TIMEOUT_CYC cycles after the last byte, pkt_ready stays 1, tx_done stays 0, and the next IN token resends the same bytes.
- R8: While tx_done is 1 and pkt_ready is 0, firmware can load and arm a new packet. tx_done clears only on a write to address 2 with bit 0 set.
- R9: A SETUP token (tok_kind 2) is answered with resp_kind 2 (ACK) and sets setup_seen. An OUT token (tok_kind 1) is answered NAK while setup_seen is 1 and ACK otherwise. Clear-register bits 1 and 2 clear setup_seen and wr_err.
- R10: When a hardware set of tx_done or setup_seen falls in the same cycle as a clear write for that flag, the flag is 1 afterwards.
- R11: While tx_valid is 1 and tx_ready is 0, tx_data and tx_last hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 data port, 1 set register, 2 clear register |
| wr_data | input | 8 | Write data |
| pkt_ready | output | 1 | Packet armed for the next IN token |
| tx_done | output | 1 | Packet acknowledged by the host |
| setup_seen | output | 1 | SETUP token received |
| wr_err | output | 1 | Sticky flag for rejected data-port writes |
| irq | output | 1 | Endpoint interrupt |
| fifo_level | output | $clog2(DEPTH+1) | Bytes held in the FIFO |
| tok_valid | input | 1 | Token present |
| tok_kind | input | 2 | 0 IN, 1 OUT, 2 SETUP |
| tok_ready | output | 1 | Engine can take a token |
| resp_valid | output | 1 | One-cycle handshake decision strobe |
| resp_kind | output | 2 | 0 DATA, 1 NAK, 2 ACK |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Consumer takes the byte |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Final byte of the packet |
| hs_ack | input | 1 | Host ACK for the sent data packet |

## Verification
Two collisions are provoked. In the first, the host ACK of a second packet arrives in the same cycle as the firmware write that clears the first completion. In the second, a SETUP token is accepted in the same cycle as the write that clears setup-seen. In both cases the bench samples the flag on the next falling edge and requires it to read 1, then issues a lone clear and requires 0. The bench also loads and arms a packet while the completion flag is still set, to show that the ready and completion flags move independently.

// File: rtl/ep_tx_pkg.sv
package ep_tx_pkg;
  localparam logic [1:0] TOK_IN    = 2'd0;
  localparam logic [1:0] TOK_OUT   = 2'd1;
  localparam logic [1:0] TOK_SETUP = 2'd2;

  localparam logic [1:0] RSP_DATA = 2'd0;
  localparam logic [1:0] RSP_NAK  = 2'd1;
  localparam logic [1:0] RSP_ACK  = 2'd2;

  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_SET  = 2'd1;
  localparam logic [1:0] REG_CLR  = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_RESP, S_STREAM, S_WAIT} eng_state_e;
endpackage

// File: rtl/ep_tx_fifo.sv
module ep_tx_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_req,
  input  logic                       blocked,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  input  logic                       rewind,
  input  logic                       release_i,
  output logic                       push_rej,
  output logic [DW-1:0]              head,
  output logic                       empty,
  output logic                       last,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          full, push_ok;

  assign full     = (cnt == CW'(DEPTH));
  assign push_ok  = push_req && !blocked && !full;
  assign push_rej = push_req && (blocked || full);
  assign empty    = (cnt == '0);
  assign last     = ((CW'(rd_ptr) + CW'(1)) == cnt);
  assign head     = mem[rd_ptr];
  assign level    = cnt;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (release_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) begin
        wr_ptr <= wr_ptr + AW'(1);
        cnt    <= cnt + CW'(1);
      end
      if (rewind)   rd_ptr <= '0;
      else if (pop) rd_ptr <= rd_ptr + AW'(1);
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_pop_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (CW'(rd_ptr) < cnt));
  p_reject_holds_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_rej && !release_i) |=> $stable(cnt));
endmodule

// File: rtl/ep_tx_flags.sv
module ep_tx_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       ack_evt,
  input  logic       setup_evt,
  input  logic       err_evt,
  input  logic [2:0] clr,
  output logic       ready,
  output logic       done,
  output logic       setup,
  output logic       err,
  output logic       irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready <= 1'b0;
      done  <= 1'b0;
      setup <= 1'b0;
      err   <= 1'b0;
    end else begin
      if (ack_evt)  ready <= 1'b0;
      else if (arm) ready <= 1'b1;

      if (ack_evt)     done <= 1'b1;
      else if (clr[0]) done <= 1'b0;

      if (setup_evt)   setup <= 1'b1;
      else if (clr[1]) setup <= 1'b0;

      if (err_evt)     err <= 1'b1;
      else if (clr[2]) err <= 1'b0;
    end
  end

  assign irq = done | setup;

  p_done_by_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(ack_evt));
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && clr[0]) |=> done);
  p_setup_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_evt && clr[1]) |=> setup);
endmodule

// File: rtl/ep_tx_engine.sv
module ep_tx_engine
  import ep_tx_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok_valid,
  input  logic [1:0]    tok_kind,
  output logic          tok_ready,
  input  logic          pkt_ready,
  input  logic          setup_seen,
  input  logic          fifo_empty,
  input  logic          fifo_last,
  input  logic [DW-1:0] fifo_head,
  output logic          resp_valid,
  output logic [1:0]    resp_kind,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          tx_last,
  input  logic          tx_ready,
  input  logic          hs_ack,
  output logic          pop,
  output logic          rewind,
  output logic          ack_evt,
  output logic          setup_evt
);
  localparam int TW = $clog2(TIMEOUT_CYC+1);

  eng_state_e    st;
  logic [1:0]    kind_q;
  logic          send_q;
  logic [TW-1:0] tmr;
  logic          tok_fire, send_d, timeout;
  logic [1:0]    rsp_d;

  assign tok_ready = (st == S_IDLE);
  assign tok_fire  = tok_valid && tok_ready;

  always_comb begin
    send_d = 1'b0;
    rsp_d  = RSP_NAK;
    case (tok_kind)
      TOK_IN: begin
        send_d = pkt_ready;
        rsp_d  = pkt_ready ? RSP_DATA : RSP_NAK;
      end
      TOK_OUT:   rsp_d = setup_seen ? RSP_NAK : RSP_ACK;
      TOK_SETUP: rsp_d = RSP_ACK;
      default:   rsp_d = RSP_NAK;
    endcase
  end

  assign rewind    = tok_fire && send_d;
  assign setup_evt = tok_fire && (tok_kind == TOK_SETUP);
  assign pop       = (st == S_STREAM) && tx_ready;
  assign ack_evt   = (st == S_WAIT) && hs_ack;
  assign timeout   = (st == S_WAIT) && !hs_ack && (tmr == TW'(TIMEOUT_CYC-1));

  assign resp_valid = (st == S_RESP);
  assign resp_kind  = kind_q;
  assign tx_valid   = (st == S_STREAM);
  assign tx_data    = fifo_head;
  assign tx_last    = (st == S_STREAM) && fifo_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      kind_q <= RSP_DATA;
      send_q <= 1'b0;
      tmr    <= '0;
    end else begin
      case (st)
        S_IDLE: if (tok_fire) begin
          kind_q <= rsp_d;
          send_q <= send_d;
          st     <= S_RESP;
        end
        S_RESP: begin
          tmr <= '0;
          if (!send_q)        st <= S_IDLE;
          else if (fifo_empty) st <= S_WAIT;
          else                st <= S_STREAM;
        end
        S_STREAM: if (tx_ready && fifo_last) st <= S_WAIT;
        S_WAIT: begin
          if (ack_evt || timeout) st <= S_IDLE;
          else                    tmr <= tmr + TW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
  p_resp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  p_resp_follows_token_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tok_fire |=> resp_valid);
endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl
  import ep_tx_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int DW          = 8,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [1:0]                 wr_addr,
  input  logic [DW-1:0]              wr_data,
  output logic                       pkt_ready,
  output logic                       tx_done,
  output logic                       setup_seen,
  output logic                       wr_err,
  output logic                       irq,
  output logic [$clog2(DEPTH+1)-1:0] fifo_level,
  input  logic                       tok_valid,
  input  logic [1:0]                 tok_kind,
  output logic                       tok_ready,
  output logic                       resp_valid,
  output logic [1:0]                 resp_kind,
  output logic                       tx_valid,
  input  logic                       tx_ready,
  output logic [DW-1:0]              tx_data,
  output logic                       tx_last,
  input  logic                       hs_ack
);
  logic          push_req, push_rej, arm;
  logic [2:0]    clr;
  logic          pop, rewind, ack_evt, setup_evt;
  logic          f_empty, f_last;
  logic [DW-1:0] f_head;

  assign push_req = wr_en && (wr_addr == REG_DATA);
  assign arm      = wr_en && (wr_addr == REG_SET) && wr_data[0];
  assign clr      = (wr_en && (wr_addr == REG_CLR)) ? wr_data[2:0] : 3'b000;

  ep_tx_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_req(push_req), .blocked(pkt_ready), .push_data(wr_data),
    .pop(pop), .rewind(rewind), .release_i(ack_evt),
    .push_rej(push_rej), .head(f_head), .empty(f_empty), .last(f_last),
    .level(fifo_level)
  );

  ep_tx_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .arm(arm), .ack_evt(ack_evt), .setup_evt(setup_evt), .err_evt(push_rej),
    .clr(clr),
    .ready(pkt_ready), .done(tx_done), .setup(setup_seen), .err(wr_err),
    .irq(irq)
  );

  ep_tx_engine #(.TIMEOUT_CYC(TIMEOUT_CYC), .DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .tok_valid(tok_valid), .tok_kind(tok_kind), .tok_ready(tok_ready),
    .pkt_ready(pkt_ready), .setup_seen(setup_seen),
    .fifo_empty(f_empty), .fifo_last(f_last), .fifo_head(f_head),
    .resp_valid(resp_valid), .resp_kind(resp_kind),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .hs_ack(hs_ack),
    .pop(pop), .rewind(rewind), .ack_evt(ack_evt), .setup_evt(setup_evt)
  );

  p_data_needs_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> pkt_ready);
  p_nak_after_setup_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_ready && tok_kind == TOK_OUT && setup_seen)
      |=> (resp_valid && resp_kind == RSP_NAK));
  p_ready_falls_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pkt_ready) |-> tx_done);
  p_nak_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_ready && tok_kind == TOK_IN && !pkt_ready)
      |=> (resp_valid && resp_kind == RSP_NAK));
endmodule

// File: tb/tb_usb_in_ep_ctrl.sv
module tb_usb_in_ep_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0; logic [1:0] wr_addr = '0; logic [7:0] wr_data = '0;
  logic pkt_ready, tx_done, setup_seen, wr_err, irq;
  logic [6:0] fifo_level;
  logic tok_valid = 1'b0; logic [1:0] tok_kind = '0; logic tok_ready;
  logic resp_valid; logic [1:0] resp_kind;
  logic tx_valid, tx_last; logic tx_ready = 1'b1; logic [7:0] tx_data;
  logic hs_ack = 1'b0;

  int checks = 0, fails = 0;
  logic [7:0] exp_q [DEPTH];
  logic [7:0] got_q [DEPTH+4];
  int got_n;
  bit got_last_ok;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_in_ep_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pkt_ready(pkt_ready), .tx_done(tx_done), .setup_seen(setup_seen),
    .wr_err(wr_err), .irq(irq), .fifo_level(fifo_level),
    .tok_valid(tok_valid), .tok_kind(tok_kind), .tok_ready(tok_ready),
    .resp_valid(resp_valid), .resp_kind(resp_kind),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .hs_ack(hs_ack)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic load_pkt(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      exp_q[i] = 8'((seed + 7*i) & 8'hff);
      reg_wr(2'd0, exp_q[i]);
    end
  endtask

  // Leaves the bench at the falling edge where resp_valid is visible.
  task automatic token(input logic [1:0] k, output int rk);
    @(negedge clk); tok_valid = 1'b1; tok_kind = k;
    @(negedge clk); tok_valid = 1'b0;
    chk("R4 resp strobe one cycle after token", int'(resp_valid), 1);
    rk = int'(resp_kind);
  endtask

  task automatic collect(input bit bp);
    logic [7:0] pd; logic pl; bit pstall; int cyc;
    got_n = 0; got_last_ok = 1'b0; pstall = 1'b0; pd = '0; pl = 1'b0;
    for (cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      tx_ready = bp ? ((cyc % 3) != 1) : 1'b1;
      if (pstall) begin
        chk("R11 data held under stall", int'(tx_data), int'(pd));
        chk("R11 last held under stall", int'(tx_last), int'(pl));
      end
      pstall = tx_valid && !tx_ready; pd = tx_data; pl = tx_last;
      if (tx_valid && tx_ready) begin
        got_q[got_n] = tx_data; got_n++;
        if (tx_last) begin got_last_ok = 1'b1; break; end
      end
    end
    tx_ready = 1'b1;
  endtask

  task automatic verify_stream(input string req, input int n);
    chk({req, " byte count"}, got_n, n);
    chk({req, " last marker"}, int'(got_last_ok), 1);
    for (int i = 0; i < n && i < got_n; i++)
      chk({req, " byte value"}, int'(got_q[i]), int'(exp_q[i]));
  endtask

  task automatic host_ack(input bit clr_same);
    @(negedge clk); hs_ack = 1'b1;
    if (clr_same) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h01; end
    @(negedge clk); hs_ack = 1'b0; wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 pkt_ready", int'(pkt_ready), 0);
    chk("R1 tx_done", int'(tx_done), 0);
    chk("R1 setup_seen", int'(setup_seen), 0);
    chk("R1 wr_err", int'(wr_err), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 fifo_level", int'(fifo_level), 0);
    chk("R1 tok_ready", int'(tok_ready), 1);
    chk("R1 tx_valid", int'(tx_valid), 0);
    chk("R1 resp_valid", int'(resp_valid), 0);
  endtask

  task automatic t_nak_unarmed;
    int rk;
    load_pkt(3, 5);
    chk("R2 level after three writes", int'(fifo_level), 3);
    token(2'd0, rk);
    chk("R5 unarmed IN answered NAK", rk, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5 no data when unarmed", int'(tx_valid), 0);
    end
  endtask

  task automatic t_send_ack;
    int rk;
    reg_wr(2'd1, 8'h01);
    chk("R4 armed", int'(pkt_ready), 1);
    token(2'd0, rk);
    chk("R4 armed IN answered DATA", rk, 0);
    collect(1'b0);
    verify_stream("R4", 3);
    host_ack(1'b0);
    chk("R6 done after ack", int'(tx_done), 1);
    chk("R6 ready cleared", int'(pkt_ready), 0);
    chk("R6 fifo released", int'(fifo_level), 0);
    chk("R6 irq with done", int'(irq), 1);
  endtask

  task automatic t_next_while_done;
    int rk;
    load_pkt(5, 40);
    chk("R8 load while done", int'(fifo_level), 5);
    reg_wr(2'd1, 8'h01);
    chk("R8 armed while done", int'(pkt_ready), 1);
    chk("R8 done still set", int'(tx_done), 1);
    token(2'd0, rk);
    chk("R4 second packet DATA", rk, 0);
    collect(1'b1);
    verify_stream("R11", 5);
    host_ack(1'b1);
    chk("R10 ack beats same-cycle clear", int'(tx_done), 1);
    reg_wr(2'd2, 8'h01);
    chk("R8 done cleared by write", int'(tx_done), 0);
    chk("R8 irq low after clear", int'(irq), 0);
  endtask

  task automatic t_timeout;
    int rk;
    load_pkt(4, 90);
    reg_wr(2'd1, 8'h01);
    token(2'd0, rk);
    collect(1'b0);
    repeat (30) @(negedge clk);
    chk("R7 ready kept after timeout", int'(pkt_ready), 1);
    chk("R7 done clear after timeout", int'(tx_done), 0);
    chk("R7 engine idle after timeout", int'(tok_ready), 1);
    token(2'd0, rk);
    chk("R7 retry answered DATA", rk, 0);
    collect(1'b0);
    verify_stream("R7 resend", 4);
    host_ack(1'b0);
    chk("R7 done after late ack", int'(tx_done), 1);
    reg_wr(2'd2, 8'h01);
  endtask

  task automatic t_zlp;
    int rk;
    reg_wr(2'd1, 8'h01);
    token(2'd0, rk);
    chk("R4 empty packet DATA", rk, 0);
    @(negedge clk);
    chk("R4 empty packet sends nothing", int'(tx_valid), 0);
    hs_ack = 1'b1; @(negedge clk); hs_ack = 1'b0;
    chk("R6 empty packet acked", int'(tx_done), 1);
    reg_wr(2'd2, 8'h01);
  endtask

  task automatic t_overflow;
    int rk;
    load_pkt(DEPTH, 3);
    chk("R2 full level", int'(fifo_level), DEPTH);
    chk("R3 no error yet", int'(wr_err), 0);
    reg_wr(2'd0, 8'hee);
    chk("R3 overflow ignored", int'(fifo_level), DEPTH);
    chk("R3 overflow error", int'(wr_err), 1);
    reg_wr(2'd2, 8'h04);
    chk("R9 error cleared", int'(wr_err), 0);
    reg_wr(2'd1, 8'h01);
    reg_wr(2'd0, 8'hdd);
    chk("R3 armed write ignored", int'(fifo_level), DEPTH);
    chk("R3 armed write error", int'(wr_err), 1);
    token(2'd0, rk);
    collect(1'b0);
    verify_stream("R3 contents intact", DEPTH);
    host_ack(1'b0);
    reg_wr(2'd2, 8'h05);
  endtask

  task automatic t_setup;
    int rk;
    token(2'd1, rk);
    chk("R9 OUT without setup ACK", rk, 2);
    token(2'd2, rk);
    chk("R9 SETUP answered ACK", rk, 2);
    chk("R9 setup flag", int'(setup_seen), 1);
    chk("R6 irq from setup", int'(irq), 1);
    token(2'd1, rk);
    chk("R9 OUT after setup NAK", rk, 1);
    @(negedge clk); tok_valid = 1'b1; tok_kind = 2'd2;
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h02;
    @(negedge clk); tok_valid = 1'b0; wr_en = 1'b0;
    chk("R10 setup beats same-cycle clear", int'(setup_seen), 1);
    reg_wr(2'd2, 8'h02);
    chk("R9 setup cleared", int'(setup_seen), 0);
    token(2'd1, rk);
    chk("R9 OUT after clear ACK", rk, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nak_unarmed();
    t_send_ack();
    t_next_while_done();
    t_timeout();
    t_zlp();
    t_overflow();
    t_setup();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule